// File: doc/BRIEF.md
# Serial Transmitter with Fractional Bit-Rate Divisor

This block turns bytes into asynchronous serial frames on a single output line. A producer hands over one byte at a time through a valid/ready handshake. The byte lands in a one-entry holding register, which the shift stage takes as soon as it is free. A frame is a low start bit, then the data bits with the least significant first, then an optional parity bit, then one or two high stop bits. The line rests high between frames.

The frame format comes from an 8-bit line-control word. The bit rate comes from an integer divisor and a 3-bit fraction. Together these give a bit time of 16×(divisor+1)+fraction reference-clock cycles, so the rate can be trimmed in steps of one sixteenth of the coarse step. A divisor of zero marks the setup as invalid, and in that case nothing is sent. The format, the divisor and the fraction are all captured when a frame starts, so software can change them at any time without corrupting a frame already on the line. Two flags report whether the holding register is free and whether the whole transmitter has gone quiet.

Top module: `uart_frac_tx`

## Requirements
- R1: During and straight after reset, tx_out is 1, tx_ready is 1, buf_empty is 1 and xmit_empty is 1.
- R2: line_ctrl[1:0] plus 5 gives the number of data bits (5 to 8). The data bits follow a single low start bit, least significant first, and data bits above that count are not sent.
- R3: line_ctrl[2] set gives two high stop bits. line_ctrl[2] clear gives one.
- R4: line_ctrl[5] set inserts a parity bit after the data bits. With line_ctrl[3] set the parity is even (the data ones plus the parity bit add up to an even number). With line_ctrl[3] clear the parity is odd.
- R5: line_ctrl[6], along with bits 4 and 7, has no effect on the frame that is sent.
- R6: Every bit of a frame, the start bit included, lasts exactly 16×(baud_div+1)+baud_frac cycles of clk.
- R7: While baud_div is zero, no frame starts and tx_out stays high. An accepted byte is held, not dropped, and goes out once baud_div becomes non-zero.
- R8: Accepting a byte clears both buf_empty and xmit_empty on the next cycle. buf_empty (equal to tx_ready) returns to 1 when the shift stage takes the byte. xmit_empty returns to 1 in the first cycle after the last stop bit, once no byte is waiting.
- R9: A change to line_ctrl, baud_div or baud_frac while a frame is on the line does not alter that frame. The new setting applies from the next frame on.
- R10: A byte accepted while a frame is being sent starts in the cycle right after the last stop bit of that frame, with no idle time in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_ctrl | input | 8 | Frame format: [1:0] data length minus 5, [2] two stop bits, [3] even parity, [5] parity on; [4], [6] and [7] are ignored |
| baud_div | input | DIV_W | Integer bit-rate divisor; zero disables transmission |
| baud_frac | input | 3 | Fractional trim added to the bit time in clock cycles |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | tx_data is offered |
| tx_ready | output | 1 | Holding register is free, so a byte can be taken |
| tx_out | output | 1 | Serial line, idles high |
| buf_empty | output | 1 | Holding register empty |
| xmit_empty | output | 1 | No byte is waiting and no frame is on the line |

## Verification
The assertions watch the invariants on every cycle. The bit-rate counter only ticks while a frame is active. The line holds steady between ticks. A frame always opens with a low level. A held byte is never lost. Nothing starts while the divisor is zero. Both flags fall after a handshake. The frame content depends on the setup, so only the bench scenarios can show it. Those scenarios cover the bit order, the data length, the parity value, the stop count, the exact bit length for each divisor and fraction, and the fact that a mid-frame setting change is ignored. They also show that a queued byte follows the previous frame with no gap.

// File: rtl/uft_pkg.sv
package uft_pkg;

  localparam int unsigned MAX_DATA = 8;
  localparam int unsigned FRAME_W  = 12;
  localparam int unsigned LEN_W    = 4;

  typedef struct packed {
    logic [1:0] len_sel;
    logic       two_stop;
    logic       par_en;
    logic       par_even;
  } frame_cfg_t;

  function automatic logic [LEN_W-1:0] data_len(input logic [1:0] sel);
    return {2'b00, sel} + LEN_W'(5);
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(input frame_cfg_t c);
    logic [LEN_W-1:0] n;
    n = LEN_W'(1) + data_len(c.len_sel) + {{(LEN_W-1){1'b0}}, c.par_en};
    n = n + (c.two_stop ? LEN_W'(2) : LEN_W'(1));
    return n;
  endfunction

  function automatic logic parity_bit(input frame_cfg_t c, input logic [MAX_DATA-1:0] d);
    logic acc;
    int   n;
    acc = 1'b0;
    n   = int'(data_len(c.len_sel));
    for (int i = 0; i < int'(MAX_DATA); i++) begin
      if (i < n) acc = acc ^ d[i];
    end
    return c.par_even ? acc : ~acc;
  endfunction

  // Bit 0 leaves the line first; unused positions stay high (stop level).
  function automatic logic [FRAME_W-1:0] build_frame(input frame_cfg_t c,
                                                     input logic [MAX_DATA-1:0] d);
    logic [FRAME_W-1:0] f;
    int n;
    f    = '1;
    f[0] = 1'b0;
    n    = int'(data_len(c.len_sel));
    for (int i = 0; i < int'(MAX_DATA); i++) begin
      if (i < n) f[i+1] = d[i];
    end
    if (c.par_en) f[n+1] = parity_bit(c, d);
    return f;
  endfunction

endpackage

// File: rtl/uft_baud.sv
module uft_baud #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned FRAC_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              run,
  input  logic [DIV_W-1:0]  div,
  input  logic [FRAC_W-1:0] frac,
  output logic              tick
);
  localparam int unsigned CNT_W = DIV_W + 5;

  function automatic logic [CNT_W-1:0] bit_period(input logic [DIV_W-1:0] d,
                                                  input logic [FRAC_W-1:0] f);
    logic [CNT_W-1:0] base;
    base = {{(CNT_W-DIV_W){1'b0}}, d} << 4;
    return base + CNT_W'(16) + {{(CNT_W-FRAC_W){1'b0}}, f};
  endfunction

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] per_q;
  logic             at_end;

  assign at_end = (cnt == per_q - CNT_W'(1));
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      per_q <= CNT_W'(16);
    end else if (restart) begin
      cnt   <= '0;
      per_q <= bit_period(div, frac);
    end else if (run) begin
      cnt <= at_end ? '0 : cnt + CNT_W'(1);
    end
  end

  assert_count_in_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < per_q));

endmodule

// File: rtl/uft_shifter.sv
module uft_shifter
  import uft_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [MAX_DATA-1:0] load_data,
  input  frame_cfg_t          load_cfg,
  input  logic                tick,
  output logic                busy,
  output logic                line,
  output logic                last_tick
);
  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   left;

  assign last_tick = busy && tick && (left == LEN_W'(1));
  assign line      = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      left  <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      shreg <= build_frame(load_cfg, load_data);
      left  <= frame_len(load_cfg);
      busy  <= 1'b1;
    end else if (busy && tick) begin
      shreg <= {1'b1, shreg[FRAME_W-1:1]};
      left  <= left - LEN_W'(1);
      if (left == LEN_W'(1)) busy <= 1'b0;
    end
  end

  assert_len_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (left != '0));

endmodule

// File: rtl/uart_frac_tx.sv
module uart_frac_tx
  import uft_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       line_ctrl,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [2:0]       baud_frac,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             tx_out,
  output logic             buf_empty,
  output logic             xmit_empty
);
  logic       hold_vld;
  logic [7:0] hold_data;
  logic       busy;
  logic       baud_tick;
  logic       frame_end;
  logic       div_ok;
  logic       start_evt;
  logic       accept_evt;
  frame_cfg_t cfg_now;
  logic       unused_lc;

  assign unused_lc = ^{line_ctrl[7:6], line_ctrl[4]};

  always_comb begin
    cfg_now.len_sel  = line_ctrl[1:0];
    cfg_now.two_stop = line_ctrl[2];
    cfg_now.par_even = line_ctrl[3];
    cfg_now.par_en   = line_ctrl[5];
  end

  assign div_ok     = (baud_div != '0);
  assign accept_evt = tx_valid && tx_ready;
  assign start_evt  = hold_vld && div_ok && (!busy || frame_end);

  assign tx_ready   = !hold_vld;
  assign buf_empty  = !hold_vld;
  assign xmit_empty = !hold_vld && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld  <= 1'b0;
      hold_data <= '0;
    end else if (accept_evt) begin
      hold_vld  <= 1'b1;
      hold_data <= tx_data;
    end else if (start_evt) begin
      hold_vld  <= 1'b0;
    end
  end

  uft_baud #(.DIV_W(DIV_W), .FRAC_W(3)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start_evt),
    .run     (busy),
    .div     (baud_div),
    .frac    (baud_frac),
    .tick    (baud_tick)
  );

  uft_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_evt),
    .load_data (hold_data),
    .load_cfg  (cfg_now),
    .tick      (baud_tick),
    .busy      (busy),
    .line      (tx_out),
    .last_tick (frame_end)
  );

  assert_tick_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> busy);

  assert_bit_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !baud_tick) |=> $stable(tx_out));

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !tx_out);

  assert_held_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_vld && !start_evt) |=> hold_vld);

  assert_no_start_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_ok && !busy) |=> !busy);

  assert_flags_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (!buf_empty && !xmit_empty));

endmodule

// File: tb/test_uart_frac_tx.sv
module test_uart_frac_tx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  lc;
  logic [15:0] dv;
  logic [2:0]  fr;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready, tx_out, buf_empty, xmit_empty;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  uart_frac_tx #(.DIV_W(16)) i_uart_frac_tx (
    .clk(clk), .rst_n(rst_n), .line_ctrl(lc), .baud_div(dv), .baud_frac(fr),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_out(tx_out), .buf_empty(buf_empty), .xmit_empty(xmit_empty)
  );

  // {line_ctrl, divisor, fraction, data}
  localparam int NV = 9;
  localparam logic [26:0] VEC [NV] = '{
    {8'h03, 8'd1, 3'd0, 8'hA5},
    {8'h00, 8'd1, 3'd3, 8'h35},
    {8'h07, 8'd2, 3'd7, 8'h3C},
    {8'h2B, 8'd1, 3'd1, 8'h81},
    {8'h23, 8'd1, 3'd0, 8'h81},
    {8'h2A, 8'd1, 3'd5, 8'hFF},
    {8'h65, 8'd1, 3'd2, 8'h2D},
    {8'h25, 8'd1, 3'd2, 8'h2D},
    {8'h02, 8'd3, 3'd4, 8'h7F}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  function automatic int e_len(input logic [7:0] c);
    return 1 + (int'(c[1:0]) + 5) + int'(c[5]) + (c[2] ? 2 : 1);
  endfunction

  function automatic logic [11:0] e_frame(input logic [7:0] c, input logic [7:0] d);
    logic [11:0] v;
    int nd, ones;
    v = 12'hFFF; v[0] = 1'b0; ones = 0;
    nd = int'(c[1:0]) + 5;
    for (int k = 0; k < nd; k++) begin
      v[k+1] = d[k];
      ones += int'(d[k]);
    end
    if (c[5]) v[nd+1] = c[3] ? logic'(ones % 2 == 1) : logic'(ones % 2 == 0);
    return v;
  endfunction

  function automatic int e_period(input logic [15:0] d, input logic [2:0] f);
    return 16 * (int'(d) + 1) + int'(f);
  endfunction

  task automatic push(input logic [7:0] b);
    while (!tx_ready) @(negedge clk);
    tx_data  = b;
    tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(!buf_empty && !xmit_empty, "R8 flags drop after write", {buf_empty, xmit_empty}, 0);
  endtask

  task automatic cap(input int n, input int p, output logic [11:0] got,
                     output logic s_end, output logic s_next, output logic xe_pre,
                     output logic xe_post, output logic be0, output int waited);
    got = 12'hFFF; waited = 0;
    s_end = 1'bx; s_next = 1'bx; xe_pre = 1'bx; xe_post = 1'bx; be0 = 1'bx;
    while (tx_out !== 1'b0 && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    for (int c = 0; c <= n * p; c++) begin
      if (c > 0) @(negedge clk);
      if (c == 0) be0 = buf_empty;
      if ((c % p) == p / 2 && (c / p) < n) got[c / p] = tx_out;
      if (c == p - 1) s_end = tx_out;
      if (c == p) s_next = tx_out;
      if (c == n * p - 1) xe_pre = xmit_empty;
      if (c == n * p) xe_post = xmit_empty;
    end
  endtask

  task automatic frame_checks(input logic [7:0] c, input logic [15:0] d, input logic [2:0] f,
                              input logic [7:0] data, input logic [11:0] got, input logic s_end,
                              input logic s_next, input logic xe_pre, input logic xe_post,
                              input logic be0, input bit idle_after);
    logic [11:0] ev;
    ev = e_frame(c, data);
    chk(got === ev, "R2 R3 R4 R5 frame bits", got, ev);
    chk(s_end === 1'b0 && s_next === ev[1], "R6 bit time", {s_end, s_next}, {1'b0, ev[1]});
    chk(be0 === 1'b1, "R8 buf_empty at start bit", be0, 1);
    chk(xe_pre === 1'b0 && xe_post === logic'(idle_after), "R8 xmit_empty after stop",
        {xe_pre, xe_post}, {1'b0, idle_after});
    if (f == 3'd0 && d == 16'd0) $display("note: unexpected zero divisor");
  endtask

  initial begin
    int done_flag;
    done_flag = 0;
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [11:0] got;
    logic s_end, s_next, xe_pre, xe_post, be0;
    int waited, bad;

    rst_n = 1'b0; lc = 8'h03; dv = 16'd1; fr = 3'd0; tx_data = '0; tx_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_out && tx_ready && buf_empty && xmit_empty, "R1 in reset",
        {tx_out, tx_ready, buf_empty, xmit_empty}, 4'hF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(tx_out && tx_ready && buf_empty && xmit_empty, "R1 after reset",
        {tx_out, tx_ready, buf_empty, xmit_empty}, 4'hF);

    // Table walk: formats, parity, stop count, divisor/fraction
    for (int e = 0; e < NV; e++) begin
      lc = VEC[e][26:19]; dv = {8'd0, VEC[e][18:11]}; fr = VEC[e][10:8];
      fork
        push(VEC[e][7:0]);
        cap(e_len(lc), e_period(dv, fr), got, s_end, s_next, xe_pre, xe_post, be0, waited);
      join
      frame_checks(lc, dv, fr, VEC[e][7:0], got, s_end, s_next, xe_pre, xe_post, be0, 1'b1);
      repeat (3) @(negedge clk);
    end

    // R7: zero divisor holds the byte
    lc = 8'h03; dv = 16'd0; fr = 3'd0;
    push(8'h96);
    bad = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (tx_out !== 1'b1) bad++;
    end
    chk(bad == 0, "R7 line idle while divisor zero", bad, 0);
    chk(!tx_ready && !xmit_empty && !buf_empty, "R7 byte held", {tx_ready, xmit_empty, buf_empty}, 0);
    dv = 16'd1;
    cap(e_len(lc), e_period(dv, fr), got, s_end, s_next, xe_pre, xe_post, be0, waited);
    chk(got === e_frame(8'h03, 8'h96), "R7 held byte sent later", got, e_frame(8'h03, 8'h96));
    repeat (3) @(negedge clk);

    // R9: mid-frame setup change is ignored for the current frame
    lc = 8'h03; dv = 16'd1; fr = 3'd0;
    fork
      push(8'h5A);
      cap(10, 32, got, s_end, s_next, xe_pre, xe_post, be0, waited);
      begin
        repeat (40) @(negedge clk);
        lc = 8'h2F; dv = 16'd3; fr = 3'd6;
      end
    join
    chk(got === e_frame(8'h03, 8'h5A), "R9 frame keeps old format", got, e_frame(8'h03, 8'h5A));
    chk(xe_pre === 1'b0 && xe_post === 1'b1, "R9 frame keeps old bit time", {xe_pre, xe_post}, 2'b01);
    // next frame uses the new setup
    fork
      push(8'hC3);
      cap(e_len(lc), e_period(dv, fr), got, s_end, s_next, xe_pre, xe_post, be0, waited);
    join
    frame_checks(lc, dv, fr, 8'hC3, got, s_end, s_next, xe_pre, xe_post, be0, 1'b1);
    repeat (3) @(negedge clk);

    // R10: queued byte follows with no gap
    lc = 8'h03; dv = 16'd1; fr = 3'd0;
    fork
      begin push(8'h81); push(8'h3F); end
      cap(10, 32, got, s_end, s_next, xe_pre, xe_post, be0, waited);
    join
    chk(got === e_frame(8'h03, 8'h81), "R10 first frame", got, e_frame(8'h03, 8'h81));
    chk(xe_post === 1'b0, "R10 transmitter stays busy", xe_post, 0);
    cap(10, 32, got, s_end, s_next, xe_pre, xe_post, be0, waited);
    chk(waited == 0, "R10 no idle gap", waited, 0);
    chk(got === e_frame(8'h03, 8'h3F), "R10 second frame", got, e_frame(8'h03, 8'h3F));
    chk(xe_post === 1'b1 && tx_out === 1'b1, "R8 idle after queue drains", {xe_post, tx_out}, 2'b11);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule